// File: doc/BRIEF.md
# GPIO Signal Routing Matrix

This block is a configurable crossbar that sits between a bank of GPIO pads and the on-chip peripherals. For every pad, one register picks which internal signal drives the pad's output value. A second register picks which internal signal drives the pad's output enable. Each of these selections can be inverted. For every peripheral input, a third kind of register picks which pad, or which constant level, feeds that input.

Software programs the routing through a simple word-wide write/read port. All routing is combinational from the register contents, so a new selection takes effect in the cycle after its write. The peripherals supply two source vectors, one of output values and one of output enables. The pads supply the input vector. The block drives the pad output and pad enable vectors and the peripheral input vector. Pad electrical settings and interrupt logic belong to other blocks.

Top module: `gpio_route_matrix`

## Requirements
- R1: After a synchronous active-low reset, every output and enable selector reads back as the value NUM_SRC (0x30 with default parameters), every input selector reads back as 0, and all pad enables, pad outputs and peripheral inputs are 0.
- R2: Byte address 0x50 + 8n holds the output-value selector of pad n, and 0x54 + 8n holds its enable selector. Address 0x50 + 8*NUM_PADS + 4d holds the input selector of peripheral input d. Address bits 1:0 are ignored. A read returns the full 32-bit word last written.
- R3: Pad output n equals src_out[k] XOR bit 31 of its output-value selector, where k is bits 7:0 of that selector.
- R4: Pad enable n equals src_oe[k] XOR bit 31 of its enable selector, where k is bits 7:0 of that selector.
- R5: A selector index k of NUM_SRC or more yields 0 before inversion, so the pad sees exactly bit 31 of the selector.
- R6: An input selector holding 0 drives its peripheral input to 0, and one holding 1 drives it to 1. A value v from 2 to NUM_PADS+1 routes pad v-2. Any larger 32-bit value drives 0.
- R7: Changes on src_out, src_oe and pad_in reach the outputs in the same cycle without a clock edge. A selector write changes the routing from the following clock edge.
- R8: A write to an address outside the selector ranges changes no selector and no output, and a read of such an address returns 0.
- R9: Bits 30:8 of an output or enable selector have no effect on routing but are kept for readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Selector write strobe |
| cfg_addr | input | ADDR_W | Byte address of the selector |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| src_out | input | NUM_SRC | Internal output-value sources |
| src_oe | input | NUM_SRC | Internal output-enable sources |
| pad_in | input | NUM_PADS | Levels sampled at the pads |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Enable driven to each pad |
| periph_in | output | NUM_PERIPH | Signals delivered to peripheral inputs |

## Verification
The routing is tried with distinct selector patterns, each compared against a behavioural model on every clock. One pattern gives each pad its own source index, with inversion on alternate pads, which tells a wrong index from a missing inversion. Another uses indices past the source count, which separates a clean zero from aliasing into the source vector. A further pattern sets the input selectors to 0, 1, 2, NUM_PADS+1, NUM_PADS+2 and all-ones, so the constants, both ends of the pad range and the overflow cases each show a different value. Random source and pad vectors are applied under each pattern, and writes with unused bits set or to unmapped and misaligned addresses check that nothing leaks into the routing or the readback.

// File: rtl/gpio_route_pkg.sv
// Package: shared types and constants of the GPIO routing matrix.
// Assumes 32-bit selector words and an 8-bit source index field.
package gpio_route_pkg;
    typedef logic [31:0] cfg_word_t;
    localparam int IDX_W         = 8;
    localparam int INV_BIT       = 31;
    localparam int OUT_BASE_BYTE = 'h50;
    localparam int EXT_W         = 1 << IDX_W;
endpackage

// File: rtl/gpio_route_outsel.sv
// Module: one pad-side selector. Picks a source bit by index and can invert it.
// Assumes NUM_SRC <= 256. Indices past NUM_SRC read a zero from the extension.
module gpio_route_outsel
    import gpio_route_pkg::*;
#(
    parameter int NUM_SRC = 48
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic               inv,
    input  logic [NUM_SRC-1:0] src,
    output logic               pin
);
    logic [EXT_W-1:0] src_ext;

    // Zero-extend the source vector so that out-of-range indices give 0.
    always_comb begin
        src_ext = '0;
        src_ext[NUM_SRC-1:0] = src;
    end

    // Select and optionally invert.
    always_comb pin = src_ext[idx] ^ inv;
endmodule

// File: rtl/gpio_route_insel.sv
// Module: one peripheral-input selector. Value 0 and 1 are constants,
// values 2..NUM_PADS+1 pick a pad and anything larger gives 0.
// Assumes NUM_PADS <= 254.
module gpio_route_insel
    import gpio_route_pkg::*;
#(
    parameter int NUM_PADS = 64
) (
    input  cfg_word_t           sel,
    input  logic [NUM_PADS-1:0] pads,
    output logic                pin
);
    logic [EXT_W-1:0] pad_ext;
    logic [IDX_W-1:0] code;
    logic [IDX_W-1:0] pad_idx;
    logic             high_set;

    // Zero-extend the pad vector so that codes past the last pad give 0.
    always_comb begin
        pad_ext = '0;
        pad_ext[NUM_PADS-1:0] = pads;
    end

    // Split the selector into its code and the overflow flag.
    always_comb begin
        code     = sel[IDX_W-1:0];
        high_set = |sel[31:IDX_W];
        pad_idx  = code - IDX_W'(2);
    end

    // Resolve constants, pad routing and overflow.
    always_comb begin
        if (high_set)
            pin = 1'b0;
        else if (code == IDX_W'(0))
            pin = 1'b0;
        else if (code == IDX_W'(1))
            pin = 1'b1;
        else
            pin = pad_ext[pad_idx];
    end
endmodule

// File: rtl/gpio_route_regs.sv
// Module: selector register file with a byte-addressed write/read port.
// Output selectors sit as pairs (value, enable) from OUT_BASE_BYTE with an
// 8-byte stride. Input selectors follow with a 4-byte stride. Address bits 1:0
// are ignored, reads are combinational and unmapped reads return 0.
module gpio_route_regs
    import gpio_route_pkg::*;
#(
    parameter int NUM_PADS   = 64,
    parameter int NUM_PERIPH = 32,
    parameter int NUM_SRC    = 48,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  cfg_word_t         cfg_wdata,
    output cfg_word_t         cfg_rdata,
    output cfg_word_t         out_cfg [2*NUM_PADS],
    output cfg_word_t         in_cfg  [NUM_PERIPH]
);
    localparam int        OUT_WORDS = 2 * NUM_PADS;
    localparam int        OUT_FIRST = OUT_BASE_BYTE / 4;
    localparam int        IN_FIRST  = OUT_FIRST + OUT_WORDS;
    localparam int        IN_END    = IN_FIRST + NUM_PERIPH;
    localparam cfg_word_t OUT_RST   = cfg_word_t'(NUM_SRC);

    logic [31:0] word_idx;
    logic [31:0] out_off;
    logic [31:0] in_off;
    logic        out_hit;
    logic        in_hit;

    // Decode the word address into region hits and offsets.
    always_comb begin
        word_idx = 32'(cfg_addr[ADDR_W-1:2]);
        out_hit  = (word_idx >= 32'(OUT_FIRST)) && (word_idx < 32'(IN_FIRST));
        in_hit   = (word_idx >= 32'(IN_FIRST)) && (word_idx < 32'(IN_END));
        out_off  = word_idx - 32'(OUT_FIRST);
        in_off   = word_idx - 32'(IN_FIRST);
    end

    // Selector storage: reset to non-driving sources, then load on write hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < OUT_WORDS; k++) out_cfg[k] <= OUT_RST;
            for (int d = 0; d < NUM_PERIPH; d++) in_cfg[d] <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < OUT_WORDS; k++)
                if (out_hit && out_off == 32'(k)) out_cfg[k] <= cfg_wdata;
            for (int d = 0; d < NUM_PERIPH; d++)
                if (in_hit && in_off == 32'(d)) in_cfg[d] <= cfg_wdata;
        end
    end

    // Read multiplexer over both regions.
    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < OUT_WORDS; k++)
            if (out_hit && out_off == 32'(k)) cfg_rdata = out_cfg[k];
        for (int d = 0; d < NUM_PERIPH; d++)
            if (in_hit && in_off == 32'(d)) cfg_rdata = in_cfg[d];
    end

    // A mapped write is visible on a read of the same word one cycle later.
    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && $past(out_hit || in_hit) &&
         cfg_addr[ADDR_W-1:2] == $past(cfg_addr[ADDR_W-1:2]))
        |-> cfg_rdata == $past(cfg_wdata));

    // Unmapped reads return zero.
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hit || in_hit) |-> cfg_rdata == '0);
endmodule

// File: rtl/gpio_route_matrix.sv
// Module: top of the GPIO routing matrix. Holds the selector registers and
// builds one value selector and one enable selector per pad, plus one input
// selector per peripheral input. All routing is combinational from the
// selector contents. Assumes NUM_SRC <= 255 so that the reset index is off
// the end of the source vectors and all pads start undriven.
module gpio_route_matrix
    import gpio_route_pkg::*;
#(
    parameter int NUM_PADS   = 64,
    parameter int NUM_PERIPH = 32,
    parameter int NUM_SRC    = 48,
    parameter int ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic [NUM_SRC-1:0]    src_out,
    input  logic [NUM_SRC-1:0]    src_oe,
    input  logic [NUM_PADS-1:0]   pad_in,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [NUM_PADS-1:0]   pad_oe,
    output logic [NUM_PERIPH-1:0] periph_in
);
    cfg_word_t out_cfg [2*NUM_PADS];
    cfg_word_t in_cfg  [NUM_PERIPH];
    logic      unused_cfg_bits;

    gpio_route_regs #(
        .NUM_PADS  (NUM_PADS),
        .NUM_PERIPH(NUM_PERIPH),
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .out_cfg  (out_cfg),
        .in_cfg   (in_cfg)
    );

    // Collect the selector bits that only exist for readback.
    always_comb begin
        unused_cfg_bits = 1'b0;
        for (int k = 0; k < 2 * NUM_PADS; k++)
            unused_cfg_bits = unused_cfg_bits ^ (^out_cfg[k][INV_BIT-1:IDX_W]);
    end

    for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
        gpio_route_outsel #(.NUM_SRC(NUM_SRC)) i_val (
            .idx(out_cfg[2*n][IDX_W-1:0]),
            .inv(out_cfg[2*n][INV_BIT]),
            .src(src_out),
            .pin(pad_out[n])
        );
        gpio_route_outsel #(.NUM_SRC(NUM_SRC)) i_en (
            .idx(out_cfg[2*n+1][IDX_W-1:0]),
            .inv(out_cfg[2*n+1][INV_BIT]),
            .src(src_oe),
            .pin(pad_oe[n])
        );

        // Past-the-end value index leaves only the inversion bit.
        assert_oob_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(out_cfg[2*n][IDX_W-1:0]) >= 32'(NUM_SRC))
            |-> pad_out[n] == out_cfg[2*n][INV_BIT]);

        // Past-the-end enable index leaves only the inversion bit.
        assert_oob_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(out_cfg[2*n+1][IDX_W-1:0]) >= 32'(NUM_SRC))
            |-> pad_oe[n] == out_cfg[2*n+1][INV_BIT]);
    end

    for (genvar d = 0; d < NUM_PERIPH; d++) begin : g_periph
        gpio_route_insel #(.NUM_PADS(NUM_PADS)) i_in (
            .sel (in_cfg[d]),
            .pads(pad_in),
            .pin (periph_in[d])
        );

        // Constant codes drive fixed levels.
        assert_const_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_cfg[d] == 32'd0 |-> !periph_in[d]) and
            (in_cfg[d] == 32'd1 |-> periph_in[d]));
    end

    // Leaving reset, no pad is driven and no peripheral input is high.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && periph_in == '0));
endmodule

// File: tb/test_gpio_route_matrix.sv
// Bench: behavioural model of the selectors compared against the outputs on
// every falling edge, plus directed readback and corner-case checks.
module test_gpio_route_matrix;
    localparam int NPAD = 64;
    localparam int NPER = 32;
    localparam int NSRC = 48;
    localparam int AW   = 12;
    localparam int IN_BASE = 'h50 + 8 * NPAD;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [AW-1:0]   cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic [NSRC-1:0] src_out = '0;
    logic [NSRC-1:0] src_oe = '0;
    logic [NPAD-1:0] pad_in = '0;
    logic [NPAD-1:0] pad_out;
    logic [NPAD-1:0] pad_oe;
    logic [NPER-1:0] periph_in;

    int total = 0;
    int bad = 0;
    bit running = 0;
    bit finished = 0;

    logic [31:0] m_val [NPAD];
    logic [31:0] m_en  [NPAD];
    logic [31:0] m_in  [NPER];

    gpio_route_matrix #(.NUM_PADS(NPAD), .NUM_PERIPH(NPER), .NUM_SRC(NSRC), .ADDR_W(AW))
    i_gpio_route_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_out(src_out),
        .src_oe(src_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_in(periph_in)
    );

    always #5 clk = ~clk;

    function automatic logic pick_src(logic [31:0] w, logic [NSRC-1:0] s);
        int i = int'(w[7:0]);
        logic b = (i < NSRC) ? s[i] : 1'b0;
        return b ^ w[31];
    endfunction

    function automatic logic pick_pad(logic [31:0] w, logic [NPAD-1:0] p);
        if (w == 32'd1) return 1'b1;
        if (w >= 32'd2 && w <= 32'(NPAD + 1)) return p[int'(w) - 2];
        return 1'b0;
    endfunction

    function automatic logic [NPAD-1:0] exp_out();
        logic [NPAD-1:0] r;
        for (int n = 0; n < NPAD; n++) r[n] = pick_src(m_val[n], src_out);
        return r;
    endfunction

    function automatic logic [NPAD-1:0] exp_oe();
        logic [NPAD-1:0] r;
        for (int n = 0; n < NPAD; n++) r[n] = pick_src(m_en[n], src_oe);
        return r;
    endfunction

    function automatic logic [NPER-1:0] exp_in();
        logic [NPER-1:0] r;
        for (int d = 0; d < NPER; d++) r[d] = pick_pad(m_in[d], pad_in);
        return r;
    endfunction

    // Model readback value for a byte address.
    function automatic logic [31:0] model_rd(int a);
        int w = a / 4;
        if (a >= 'h50 && a < IN_BASE) begin
            int k = (w - 'h50 / 4);
            return (k % 2 == 0) ? m_val[k / 2] : m_en[k / 2];
        end
        if (a >= IN_BASE && a < IN_BASE + 4 * NPER) return m_in[(a - IN_BASE) / 4];
        return 32'h0;
    endfunction

    function automatic void model_wr(int a, logic [31:0] d);
        int aa = a & ~3;
        if (aa >= 'h50 && aa < IN_BASE) begin
            int k = (aa - 'h50) / 4;
            if (k % 2 == 0) m_val[k / 2] = d; else m_en[k / 2] = d;
        end else if (aa >= IN_BASE && aa < IN_BASE + 4 * NPER) begin
            m_in[(aa - IN_BASE) / 4] = d;
        end
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison of all routed outputs against the model.
    always @(negedge clk) begin
        if (running && rst_n) begin
            check(pad_out == exp_out(), "R3", 64'(pad_out), 64'(exp_out()));
            check(pad_oe == exp_oe(), "R4", 64'(pad_oe), 64'(exp_oe()));
            check(periph_in == exp_in(), "R6", 64'(periph_in), 64'(exp_in()));
        end
    end

    // Called at posedge+1; returns at posedge+1 after the write edge.
    task automatic wr(int a, logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = AW'(a);
        cfg_wdata = d;
        @(posedge clk);
        model_wr(a, d);
        #1 cfg_we = 1'b0;
    endtask

    task automatic rd(int a, string req);
        cfg_addr = AW'(a);
        #1;
        check(cfg_rdata == model_rd(a & ~3), req, 64'(cfg_rdata), 64'(model_rd(a & ~3)));
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic shake(int n);
        repeat (n) begin
            src_out = NSRC'({$urandom, $urandom});
            src_oe  = NSRC'({$urandom, $urandom});
            pad_in  = {$urandom, $urandom};
            step(1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(7));
        for (int n = 0; n < NPAD; n++) begin m_val[n] = 32'(NSRC); m_en[n] = 32'(NSRC); end
        for (int d = 0; d < NPER; d++) m_in[d] = 32'h0;
        src_out = '1; src_oe = '1; pad_in = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        // R1: idle outputs straight after reset even with all sources high.
        check(pad_oe == '0, "R1", 64'(pad_oe), 64'h0);
        check(pad_out == '0, "R1", 64'(pad_out), 64'h0);
        check(periph_in == '0, "R1", 64'(periph_in), 64'h0);
        step(1);
        running = 1;
        rd('h50, "R1"); rd('h54 + 8 * 63, "R1"); rd(IN_BASE, "R1");
        shake(5);

        // R3/R4: distinct index per pad, inversion on odd pads.
        for (int n = 0; n < NPAD; n++) begin
            wr('h50 + 8 * n, {n[0], 23'h0, 8'(n % NSRC)});
            wr('h54 + 8 * n, {~n[0], 23'h0, 8'((n + 5) % NSRC)});
        end
        shake(30);

        // R5: indices past the source count.
        wr('h50 + 8 * 3, 32'h0000_00C8);
        wr('h50 + 8 * 4, 32'h8000_00C8);
        wr('h54 + 8 * 5, 32'h0000_0000 | 32'(NSRC));
        wr('h54 + 8 * 6, 32'h8000_00FF);
        src_out = '1; src_oe = '1;
        #2;
        check(pad_out[3] == 1'b0, "R5", 64'(pad_out[3]), 64'h0);
        check(pad_out[4] == 1'b1, "R5", 64'(pad_out[4]), 64'h1);
        check(pad_oe[5] == 1'b0, "R5", 64'(pad_oe[5]), 64'h0);
        check(pad_oe[6] == 1'b1, "R5", 64'(pad_oe[6]), 64'h1);
        step(1);
        shake(10);

        // R6: constants, pad range ends and overflow codes.
        wr(IN_BASE + 0, 32'd0);
        wr(IN_BASE + 4, 32'd1);
        wr(IN_BASE + 8, 32'd2);
        wr(IN_BASE + 12, 32'(NPAD + 1));
        wr(IN_BASE + 16, 32'(NPAD + 2));
        wr(IN_BASE + 20, 32'hFFFF_FFFF);
        wr(IN_BASE + 24, 32'h0000_0102);
        for (int d = 7; d < NPER; d++) wr(IN_BASE + 4 * d, 32'(2 + (d * 3) % NPAD));
        pad_in = '1;
        #2;
        check(periph_in[6:0] == 7'b000_1110, "R6", 64'(periph_in[6:0]), 64'h0E);
        shake(30);

        // R7: combinational propagation with no clock edge.
        pad_in = '0; src_out = '0;
        #1;
        check(periph_in == exp_in(), "R7", 64'(periph_in), 64'(exp_in()));
        pad_in = '1; src_out = '1;
        #1;
        check(periph_in == exp_in(), "R7", 64'(periph_in), 64'(exp_in()));
        check(pad_out == exp_out(), "R7", 64'(pad_out), 64'(exp_out()));
        step(1);
        // R7: write takes effect at the edge, not before it.
        cfg_we = 1'b1; cfg_addr = AW'('h50); cfg_wdata = 32'h8000_00FF;
        #2;
        check(pad_out[0] == exp_out()[0], "R7", 64'(pad_out[0]), 64'(exp_out()[0]));
        @(posedge clk);
        model_wr('h50, 32'h8000_00FF);
        #1 cfg_we = 1'b0;
        check(pad_out[0] == 1'b1, "R7", 64'(pad_out[0]), 64'h1);

        // R8: unmapped writes leave everything alone and read as zero.
        wr('h0, 32'hDEAD_BEEF);
        wr('h4C, 32'h8000_0001);
        wr(IN_BASE + 4 * NPER, 32'h0000_0003);
        wr('hFFC, 32'h1234_5678);
        rd('h0, "R8"); rd('h4C, "R8"); rd(IN_BASE + 4 * NPER, "R8"); rd('hFFC, "R8");
        shake(5);

        // R9: unused selector bits kept for readback, ignored for routing.
        wr('h50 + 8 * 10, 32'h7FFF_FF01);
        wr('h54 + 8 * 10, 32'hABCD_EF02);
        rd('h50 + 8 * 10, "R9"); rd('h54 + 8 * 10, "R9");
        shake(10);

        // R2: misaligned address and a full readback sweep.
        wr('h50 + 8 * 12 + 3, 32'h8000_0007);
        rd('h50 + 8 * 12, "R2");
        rd('h50 + 8 * 12 + 2, "R2");
        for (int n = 0; n < NPAD; n++) begin
            rd('h50 + 8 * n, "R2");
            rd('h54 + 8 * n, "R2");
        end
        for (int d = 0; d < NPER; d++) rd(IN_BASE + 4 * d, "R2");
        shake(10);

        running = 0;
        finish_run();
    end
endmodule